// File: doc/BRIEF.md
# Byte Queue with Serial Bridge and Status Flags

This block stores bytes in a 66-entry, byte-wide first-in first-out queue and joins that queue to a one-bit serial stream through an 8-bit shift register. In transmit mode the shift register takes bytes out of the queue and sends them most significant bit first, one bit per bit-rate tick. In receive mode it gathers incoming bits and places each completed byte in the queue. A host port can also write bytes into the queue and read them out.

Several status flags follow the queue and the serial side. The host-visible not-empty flag is refreshed only when a host access starts, which is marked by a falling chip select. The overrun flag is cleared by writing one to it, and that same pulse also empties the queue. The packet-sent flag rises only after the last serial bit has gone out. Bit-rate generation comes from outside as a tick input. Modulation and packet framing belong to neighbouring blocks.

Top module: `pkt_fifo_serdes`

## Requirements
- R1: The queue holds up to 66 bytes in first-in first-out order, and `full` is high exactly when 66 bytes are stored.
- R2: `mode` selects the operating mode: 0 is standby, 1 is transmit, 2 is receive, and 3 acts as standby. A host write is taken in standby or transmit mode and ignored in receive mode. A host read pops the oldest byte onto `hostRdData` one cycle later. It is taken in standby or receive mode and ignored in transmit mode.
- R3: A byte pushed while the queue is full is dropped and sets `overrun`. This applies to a host write and to a byte completed by the receive shift register.
- R4: A one-cycle pulse on `clrOverrun` clears `overrun` and empties the queue.
- R5: `notEmpty` is loaded with the queue occupancy only in the cycle in which `csN` is first seen low after being high. At all other times it holds its value.
- R6: `levelHigh` is high when the number of stored bytes is greater than `threshold`.
- R7: In transmit mode, a tick that finds the shift register idle and the queue non-empty pops a byte and drives its bit 7 on `serOut`. Each of the next seven ticks drives the next lower bit. The tick after bit 0 loads the next byte, so bytes follow each other without a gap.
- R8: In transmit mode with the queue empty, `serOut` stays low and the serializer waits for a byte.
- R9: `pktSent` rises on the tick that follows a byte's bit 0 when no further byte is queued. It stays high until transmit mode is entered again, and entering transmit mode clears it.
- R10: In receive mode, each tick shifts `serIn` in. The first bit of a byte becomes bit 7, and the eighth tick pushes the byte into the queue.
- R11: A change of `mode` resets the bit counter and drives `serOut` low, and any partly shifted byte is discarded.
- R12: `serOut` is low whenever the mode is not transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 standby, 1 transmit, 2 receive, 3 standby |
| bitTick | input | 1 | One-cycle strobe per serial bit period |
| serIn | input | 1 | Received serial bit |
| serOut | output | 1 | Transmitted serial bit |
| hostWrEn | input | 1 | Host push strobe |
| hostWrData | input | 8 | Host push byte |
| hostRdEn | input | 1 | Host pop strobe |
| hostRdData | output | 8 | Byte from the last accepted host pop |
| csN | input | 1 | Host chip select, active low |
| clrOverrun | input | 1 | Write-one-to-clear for overrun; also empties the queue |
| threshold | input | 7 | Level compare value |
| notEmpty | output | 1 | Queue occupancy sampled at start of host access |
| full | output | 1 | Queue holds 66 bytes |
| levelHigh | output | 1 | Stored count exceeds threshold |
| overrun | output | 1 | A push was dropped because the queue was full |
| pktSent | output | 1 | Last serial bit sent with nothing more queued |

## Verification
Some properties are checked by the assertions on every cycle. These are: `serOut` is low outside transmit mode; `notEmpty` changes only right after chip select was low; a rise of `pktSent` or `overrun` is always caused by a tick or a push; a host write into a full queue in standby raises `overrun`; the clear pulse leaves the queue empty with the flag low; and a full queue drives `levelHigh` for any threshold below the depth. Other behaviour needs the bench's directed scenarios. This covers the exact bit order on the line, back-to-back bytes, byte assembly in receive mode, the order in which bytes come out, the bytes discarded by a mode change, and the accesses that each mode ignores.

// File: rtl/pfs_pkg.sv
`timescale 1ns/1ps
package pfs_pkg;

  typedef enum logic [1:0] {
    MODE_STBY = 2'd0,
    MODE_TX   = 2'd1,
    MODE_RX   = 2'd2,
    MODE_RSVD = 2'd3
  } mode_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic push;         // write one byte into the queue
    logic pushFromSer;  // byte source is the receive shifter
    logic pop;          // remove the oldest byte
    logic popToHost;    // popped byte goes to the host data register
    logic flush;        // empty the queue
    logic srLoad;       // load shifter from queue head, drive bit 7
    logic srTxShift;    // drive next lower bit
    logic srRxShift;    // shift serial input in
    logic srIdle;       // drive serial output low
  } strobe_t;

endpackage

// File: rtl/pfs_ctrl.sv
`timescale 1ns/1ps
module pfs_ctrl
  import pfs_pkg::*;
#(
  parameter int DEPTH = 66,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic             bitTick,
  input  logic             hostWrEn,
  input  logic             hostRdEn,
  input  logic             csN,
  input  logic             clrOverrun,
  input  logic [CNT_W-1:0] threshold,
  input  logic [CNT_W-1:0] count,
  output strobe_t          strb,
  output logic             notEmpty,
  output logic             full,
  output logic             levelHigh,
  output logic             overrun,
  output logic             pktSent
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam int BIT_W = 3;

  mode_e modeNow, modeQ;
  logic isTx, isRx, isStby, modeChg;
  logic fifoEmpty, effEmpty;
  logic [BIT_W-1:0] bitCnt;
  logic busy, csNq;
  logic txGo, txShift, txLoad, txEnd, rxGo, rxDone;
  logic hostPush, hostPop, pushReq;

  assign modeNow   = mode_e'(mode);
  assign isTx      = (modeNow == MODE_TX);
  assign isRx      = (modeNow == MODE_RX);
  assign isStby    = !isTx && !isRx;
  assign modeChg   = (modeNow != modeQ);

  assign fifoEmpty = (count == '0);
  assign full      = (count == DEPTH_C);
  assign levelHigh = (count > threshold);
  assign effEmpty  = fifoEmpty || clrOverrun;

  assign txGo    = isTx && bitTick && !modeChg;
  assign txShift = txGo && busy && (bitCnt != '0);
  assign txLoad  = txGo && !txShift && !effEmpty;
  assign txEnd   = txGo && !txShift && effEmpty;
  assign rxGo    = isRx && bitTick && !modeChg;
  assign rxDone  = rxGo && (bitCnt == '1);

  assign hostPush = hostWrEn && (isTx || isStby);
  assign hostPop  = hostRdEn && (isRx || isStby);
  assign pushReq  = hostPush || rxDone;

  always_comb begin
    strb             = '0;
    strb.push        = pushReq && !full && !clrOverrun;
    strb.pushFromSer = rxDone;
    strb.pop         = (hostPop && !effEmpty) || txLoad;
    strb.popToHost   = hostPop;
    strb.flush       = clrOverrun;
    strb.srLoad      = txLoad;
    strb.srTxShift   = txShift;
    strb.srRxShift   = rxGo;
    strb.srIdle      = txEnd || modeChg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= MODE_STBY;
      bitCnt   <= '0;
      busy     <= 1'b0;
      pktSent  <= 1'b0;
      overrun  <= 1'b0;
      csNq     <= 1'b1;
      notEmpty <= 1'b0;
    end else begin
      modeQ <= modeNow;
      csNq  <= csN;

      if (modeChg)      bitCnt <= '0;
      else if (txLoad)  bitCnt <= '1;
      else if (txShift) bitCnt <= bitCnt - 1'b1;
      else if (rxGo)    bitCnt <= bitCnt + 1'b1;

      if (modeChg)     busy <= 1'b0;
      else if (txLoad) busy <= 1'b1;
      else if (txEnd)  busy <= 1'b0;

      if (modeChg && isTx)     pktSent <= 1'b0;
      else if (txEnd && busy)  pktSent <= 1'b1;

      if (clrOverrun)            overrun <= 1'b0;
      else if (pushReq && full)  overrun <= 1'b1;

      if (csNq && !csN) notEmpty <= !fifoEmpty;
    end
  end

endmodule

// File: rtl/pfs_datapath.sv
`timescale 1ns/1ps
module pfs_datapath
  import pfs_pkg::*;
#(
  parameter int DEPTH = 66,
  parameter int WIDTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [WIDTH-1:0] hostWrData,
  input  logic             serIn,
  output logic [WIDTH-1:0] hostRdData,
  output logic             serOut,
  output logic [CNT_W-1:0] count
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [WIDTH-1:0] shReg, headByte, pushByte;
  logic             doPush, doPop;

  assign headByte = mem[rdPtr];
  assign pushByte = strb.pushFromSer ? {shReg[WIDTH-2:0], serIn} : hostWrData;
  assign doPush   = strb.push && !strb.flush;
  assign doPop    = strb.pop && !strb.flush;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_P) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg      <= '0;
      serOut     <= 1'b0;
      hostRdData <= '0;
    end else begin
      if (doPop && strb.popToHost) hostRdData <= headByte;
      if (strb.srIdle) begin
        serOut <= 1'b0;
      end else if (strb.srLoad) begin
        serOut <= headByte[WIDTH-1];
        shReg  <= {headByte[WIDTH-2:0], 1'b0};
      end else if (strb.srTxShift) begin
        serOut <= shReg[WIDTH-1];
        shReg  <= {shReg[WIDTH-2:0], 1'b0};
      end else if (strb.srRxShift) begin
        shReg  <= {shReg[WIDTH-2:0], serIn};
      end
    end
  end

endmodule

// File: rtl/pkt_fifo_serdes.sv
`timescale 1ns/1ps
module pkt_fifo_serdes
  import pfs_pkg::*;
#(
  parameter int DEPTH = 66,
  parameter int WIDTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic             bitTick,
  input  logic             serIn,
  output logic             serOut,
  input  logic             hostWrEn,
  input  logic [WIDTH-1:0] hostWrData,
  input  logic             hostRdEn,
  output logic [WIDTH-1:0] hostRdData,
  input  logic             csN,
  input  logic             clrOverrun,
  input  logic [CNT_W-1:0] threshold,
  output logic             notEmpty,
  output logic             full,
  output logic             levelHigh,
  output logic             overrun,
  output logic             pktSent
);

  strobe_t          strb;
  logic [CNT_W-1:0] count;

  pfs_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .bitTick(bitTick),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .csN(csN),
    .clrOverrun(clrOverrun), .threshold(threshold), .count(count),
    .strb(strb), .notEmpty(notEmpty), .full(full), .levelHigh(levelHigh),
    .overrun(overrun), .pktSent(pktSent)
  );

  pfs_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWrData(hostWrData),
    .serIn(serIn), .hostRdData(hostRdData), .serOut(serOut), .count(count)
  );

endmodule

// File: rtl/pfs_checker.sv
`timescale 1ns/1ps
module pfs_checker #(
  parameter int DEPTH = 66,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       mode,
  input logic             bitTick,
  input logic             hostWrEn,
  input logic             csN,
  input logic             clrOverrun,
  input logic [CNT_W-1:0] threshold,
  input logic             serOut,
  input logic             full,
  input logic             levelHigh,
  input logic             overrun,
  input logic             pktSent,
  input logic             notEmpty
);

  assert_quiet_line_R12: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'd1) |=> !serOut);

  assert_ne_on_cs_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(notEmpty) |-> $past(!csN));

  assert_sent_on_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pktSent) |-> $past(bitTick));

  assert_ovr_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(hostWrEn || bitTick));

  assert_ovr_on_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    (full && hostWrEn && (mode == 2'd0) && !clrOverrun) |=> overrun);

  assert_clear_flush_R4: assert property (@(posedge clk) disable iff (!rstN)
    clrOverrun |=> (!overrun && !full && !levelHigh));

  assert_full_level_R6: assert property (@(posedge clk) disable iff (!rstN)
    (full && (int'(threshold) < DEPTH)) |-> levelHigh);

endmodule

bind pkt_fifo_serdes pfs_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_pfs_checker (
  .clk(clk), .rstN(rstN), .mode(mode), .bitTick(bitTick), .hostWrEn(hostWrEn),
  .csN(csN), .clrOverrun(clrOverrun), .threshold(threshold), .serOut(serOut),
  .full(full), .levelHigh(levelHigh), .overrun(overrun), .pktSent(pktSent),
  .notEmpty(notEmpty)
);

// File: tb/test_pkt_fifo_serdes.sv
`timescale 1ns/1ps
module test_pkt_fifo_serdes;

  localparam int DEPTH = 66;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] mode = 2'd0;
  logic bitTick = 1'b0, serIn = 1'b0, serOut;
  logic hostWrEn = 1'b0, hostRdEn = 1'b0, csN = 1'b1, clrOverrun = 1'b0;
  logic [7:0] hostWrData = 8'h00, hostRdData;
  logic [6:0] threshold = 7'd0;
  logic notEmpty, full, levelHigh, overrun, pktSent;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pkt_fifo_serdes i_pkt_fifo_serdes (
    .clk(clk), .rstN(rstN), .mode(mode), .bitTick(bitTick), .serIn(serIn),
    .serOut(serOut), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdEn(hostRdEn), .hostRdData(hostRdData), .csN(csN),
    .clrOverrun(clrOverrun), .threshold(threshold), .notEmpty(notEmpty),
    .full(full), .levelHigh(levelHigh), .overrun(overrun), .pktSent(pktSent)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic setMode(input logic [1:0] m);
    mode = m;
    step();
  endtask

  task automatic hostWrite(input logic [7:0] b);
    hostWrEn = 1'b1; hostWrData = b;
    step();
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(output logic [7:0] b);
    hostRdEn = 1'b1;
    step();
    hostRdEn = 1'b0;
    b = hostRdData;
  endtask

  task automatic csPulse();
    csN = 1'b0; step();
    csN = 1'b1; step();
  endtask

  task automatic tickBit(input logic b);
    serIn = b; bitTick = 1'b1;
    step();
    bitTick = 1'b0;
  endtask

  task automatic clearOvr();
    clrOverrun = 1'b1; step(); clrOverrun = 1'b0;
  endtask

  task automatic testReset();
    check("R1 reset full", int'(full), 0);
    check("R5 reset notEmpty", int'(notEmpty), 0);
    check("R3 reset overrun", int'(overrun), 0);
    check("R9 reset pktSent", int'(pktSent), 0);
    check("R12 reset serOut", int'(serOut), 0);
    check("R6 reset levelHigh", int'(levelHigh), 0);
  endtask

  task automatic testFillDrain();
    logic [7:0] b;
    setMode(2'd0);
    hostWrite(8'h42);
    check("R5 no refresh without cs", int'(notEmpty), 0);
    csPulse();
    check("R5 refresh on cs fall", int'(notEmpty), 1);
    hostRead(b);
    check("R1 single byte", int'(b), 8'h42);
    check("R5 held after drain", int'(notEmpty), 1);
    csPulse();
    check("R5 cleared on next cs", int'(notEmpty), 0);
    for (int i = 0; i < DEPTH; i++) hostWrite(8'(i * 3 + 1));
    check("R1 full at 66", int'(full), 1);
    threshold = 7'd65; #1;
    check("R6 count 66 > 65", int'(levelHigh), 1);
    threshold = 7'd66; #1;
    check("R6 count 66 not > 66", int'(levelHigh), 0);
    hostWrite(8'hEE);
    check("R3 host overrun", int'(overrun), 1);
    for (int i = 0; i < DEPTH; i++) begin
      hostRead(b);
      check("R1 order", int'(b), (i * 3 + 1) & 8'hFF);
    end
    check("R1 not full after drain", int'(full), 0);
    threshold = 7'd0;
  endtask

  task automatic testClear();
    hostWrite(8'h01); hostWrite(8'h02); hostWrite(8'h03);
    check("R6 count 3 > 0", int'(levelHigh), 1);
    check("R4 overrun still set", int'(overrun), 1);
    clearOvr();
    check("R4 overrun cleared", int'(overrun), 0);
    check("R4 queue emptied", int'(levelHigh), 0);
    csPulse();
    check("R4 notEmpty after clear", int'(notEmpty), 0);
  endtask

  task automatic testIgnored();
    logic [7:0] b;
    setMode(2'd2);
    hostWrite(8'h11);
    check("R2 write ignored in rx", int'(levelHigh), 0);
    setMode(2'd0);
    hostWrite(8'h5C);
    hostRead(b);
    check("R2 standby read", int'(b), 8'h5C);
    setMode(2'd1);
    hostWrite(8'h77);
    check("R2 write taken in tx", int'(levelHigh), 1);
    hostRead(b);
    check("R2 read ignored in tx data", int'(b), 8'h5C);
    check("R2 read ignored in tx level", int'(levelHigh), 1);
    setMode(2'd3);
    hostRead(b);
    check("R2 mode 3 acts as standby", int'(b), 8'h77);
  endtask

  task automatic testTx();
    logic [15:0] pat;
    pat = 16'hA53C;
    setMode(2'd1);
    tickBit(1'b0);
    check("R8 idle low", int'(serOut), 0);
    check("R9 no sent without data", int'(pktSent), 0);
    setMode(2'd0);
    hostWrite(pat[15:8]); hostWrite(pat[7:0]);
    setMode(2'd1);
    for (int i = 0; i < 16; i++) begin
      tickBit(1'b0);
      check("R7 msb first bit", int'(serOut), int'(pat[15 - i]));
      if (i == 8) check("R7 second byte popped", int'(levelHigh), 0);
      step();
      check("R7 holds between ticks", int'(serOut), int'(pat[15 - i]));
    end
    check("R9 not before end", int'(pktSent), 0);
    tickBit(1'b0);
    check("R9 sent after last bit", int'(pktSent), 1);
    check("R8 line low when empty", int'(serOut), 0);
    tickBit(1'b0);
    check("R9 stays high", int'(pktSent), 1);
    setMode(2'd0);
    check("R12 standby line low", int'(serOut), 0);
    setMode(2'd1);
    check("R9 cleared on tx entry", int'(pktSent), 0);
  endtask

  task automatic testRx();
    logic [15:0] pat;
    logic [7:0] b;
    pat = 16'h960F;
    setMode(2'd2);
    for (int i = 0; i < 16; i++) begin
      tickBit(pat[15 - i]);
      check("R12 rx line low", int'(serOut), 0);
      if (i == 6) begin
        csPulse();
        check("R10 no push before 8 bits", int'(notEmpty), 0);
      end
      if (i == 7) begin
        csPulse();
        check("R10 push on eighth bit", int'(notEmpty), 1);
      end
    end
    setMode(2'd0);
    hostRead(b);
    check("R10 first byte", int'(b), 8'h96);
    hostRead(b);
    check("R10 second byte", int'(b), 8'h0F);
  endtask

  task automatic testModeChange();
    logic [7:0] b;
    setMode(2'd2);
    for (int i = 0; i < 4; i++) tickBit(1'b1);
    setMode(2'd0);
    setMode(2'd2);
    for (int i = 0; i < 8; i++) tickBit(8'h5A >> (7 - i));
    setMode(2'd0);
    check("R11 one byte after restart", int'(levelHigh), 1);
    hostRead(b);
    check("R11 partial discarded", int'(b), 8'h5A);
    check("R11 only one byte", int'(levelHigh), 0);
    hostWrite(8'hFF); hostWrite(8'h81);
    setMode(2'd1);
    tickBit(1'b0); tickBit(1'b0); tickBit(1'b0);
    check("R7 mid byte high", int'(serOut), 1);
    setMode(2'd0);
    check("R11 line low on change", int'(serOut), 0);
    setMode(2'd1);
    tickBit(1'b0);
    check("R11 next byte bit7", int'(serOut), 1);
    tickBit(1'b0);
    check("R11 next byte bit6", int'(serOut), 0);
    setMode(2'd0);
  endtask

  task automatic testRxOverrun();
    logic [7:0] b;
    clearOvr();
    for (int i = 0; i < DEPTH; i++) hostWrite(8'(i));
    setMode(2'd2);
    for (int i = 0; i < 8; i++) tickBit(1'b1);
    check("R3 shifter overrun", int'(overrun), 1);
    check("R3 still full", int'(full), 1);
    setMode(2'd0);
    hostRead(b);
    check("R3 head intact", int'(b), 0);
    clearOvr();
    check("R4 clear after rx overrun", int'(overrun), 0);
  endtask

  initial begin
    step(); step();
    rstN = 1'b1;
    step();
    testReset();
    testFillDrain();
    testClear();
    testIgnored();
    testTx();
    testRx();
    testModeChange();
    testRxOverrun();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule